// File: doc/BRIEF.md
# DDR Burst Column Order Generator

This block produces the column index for every beat of one DDR SDRAM read or write burst. A one-cycle start pulse captures a starting column, a burst length of 2, 4 or 8 beats and an ordering choice. From the next cycle on, the block emits one column per clock on its beat clock. On that clock two beats fall in each command clock.

The low bits of the column move through a window whose size equals the burst length and which is aligned to that length. In linear-wrap order the low bits count upward and fold back to the bottom of the window. In XOR order each beat's low bits are the start bits exclusive-ORed with the beat number. The bits above the window never change during a burst. A stop input ends the burst early. A new start replaces any burst in progress, even one that began on the previous cycle, so column commands can be issued back to back.

The control is a two-state machine. ST_IDLE means no beat is driven. ST_BURST means a beat is driven every cycle. The transitions are LAUNCH (ST_IDLE to ST_BURST on start), RELAUNCH (ST_BURST to ST_BURST on start, with the counter reloaded), STEP (ST_BURST to ST_BURST when the current beat is not the final one), DRAIN (ST_BURST to ST_IDLE after the final beat with no start) and HALT (ST_BURST to ST_IDLE on stop with no start).

Top module: `burst_col_seq`

## Requirements
- R1: While reset is held and after it is released with no start, `beat_valid` and `beat_last` are 0 and `beat_col` is 0.
- R2: A start sampled on a clock edge makes `beat_valid` 1 from that edge on, and `beat_col` equals `start_col` for beat 0.
- R3: With `interleave`=0, the low bits of beat i are (start low bits + i) modulo the burst length.
- R4: With `interleave`=1, the low bits of beat i are the start low bits XOR i.
- R5: The column bits above the burst window equal those of `start_col` on every beat of the burst.
- R6: `len_sel` encodes the burst length: 2'b01 gives 2 beats, 2'b10 gives 4 beats, 2'b11 gives 8 beats, and 2'b00 is treated as 2 beats.
- R7: `beat_last` is 1 only on beat BL-1. On the cycle after that beat, `beat_valid` is 0 unless a start was sampled.
- R8: A start sampled during a burst, including on the first cycle after a previous start, discards the old burst. The next cycle shows beat 0 of the new burst.
- R9: A stop sampled during a burst makes `beat_valid` 0 on the next cycle. If start and stop are sampled together, start wins.
- R10: `start_col`, `len_sel` and `interleave` are sampled only with start. Changing them during a burst does not alter that burst's columns.
- R11: While `beat_valid` is 0, `beat_col` is 0 and `beat_last` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a burst with the current settings |
| start_col | input | 9 | Starting column index |
| len_sel | input | 2 | Burst length code |
| interleave | input | 1 | 0 = linear-wrap order, 1 = XOR order |
| stop | input | 1 | End the current burst |
| beat_valid | output | 1 | A beat is driven this cycle |
| beat_col | output | 9 | Column index of the current beat |
| beat_last | output | 1 | Current beat is the final beat of the burst |

## Verification
The hardest situations to reach are a restart on the very cycle after a start and a start coinciding with stop. In both, the register load must win over the counter advance or the halt. Directed sequences place the second start or the stop on exact negative-edge slots relative to the first launch. Random bursts change `start_col`, `len_sel` and `interleave` in the middle of every burst, so that any late sampling of these inputs shows up in the column sequence.

// File: rtl/colseq_pkg.sv
package colseq_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } seq_state_t;

    // log2 of the burst length; code 0 falls back to two beats
    function automatic logic [1:0] len_log(input logic [1:0] code);
        return (code == 2'b00) ? 2'b01 : code;
    endfunction

endpackage

// File: rtl/colseq_beat_ctr.sv
module colseq_beat_ctr #(
    parameter int MAX_BL = 8,
    localparam int IDX_W = $clog2(MAX_BL),
    localparam int LOG_W = $clog2(IDX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [LOG_W-1:0] len_log,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    logic [IDX_W-1:0] top_idx;

    always_ff @(posedge clk) begin
        if (!rst_n)       idx <= '0;
        else if (clear)   idx <= '0;
        else if (advance) idx <= idx + 1'b1;
    end

    always_comb begin
        top_idx = IDX_W'((1 << len_log) - 1);
        last    = (idx == top_idx);
    end
endmodule

// File: rtl/colseq_window.sv
module colseq_window #(
    parameter int COL_W  = 9,
    parameter int MAX_BL = 8,
    localparam int IDX_W = $clog2(MAX_BL),
    localparam int LOG_W = $clog2(IDX_W + 1)
) (
    input  logic [COL_W-1:0] base,
    input  logic [IDX_W-1:0] idx,
    input  logic [LOG_W-1:0] len_log,
    input  logic             interleave,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] step;
    logic [COL_W-1:0] low;

    always_comb begin
        mask = COL_W'((1 << len_log) - 1);
        step = COL_W'(idx);
        low  = interleave ? (base ^ step) : (base + step);
        col  = (base & ~mask) | (low & mask);
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import colseq_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int MAX_BL = 8,
    localparam int IDX_W = $clog2(MAX_BL),
    localparam int LOG_W = $clog2(IDX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [1:0]       len_sel,
    input  logic             interleave,
    input  logic             stop,
    output logic             beat_valid,
    output logic [COL_W-1:0] beat_col,
    output logic             beat_last
);
    seq_state_t       state, state_nx;
    logic [COL_W-1:0] base_q;
    logic [LOG_W-1:0] log_q;
    logic             inter_q;
    logic [IDX_W-1:0] idx;
    logic             idx_last;
    logic [COL_W-1:0] win_col;
    logic             advance;

    // Next-state decision: LAUNCH, RELAUNCH, STEP, DRAIN, HALT
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_BURST;
            ST_BURST: begin
                if (start)         state_nx = ST_BURST;
                else if (stop)     state_nx = ST_IDLE;
                else if (idx_last) state_nx = ST_IDLE;
                else               state_nx = ST_BURST;
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            log_q   <= LOG_W'(1);
            inter_q <= 1'b0;
        end else if (start) begin
            base_q  <= start_col;
            log_q   <= LOG_W'(len_log(len_sel));
            inter_q <= interleave;
        end
    end

    assign advance = (state == ST_BURST) && !start && !stop && !idx_last;

    colseq_beat_ctr #(.MAX_BL(MAX_BL)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .advance (advance),
        .len_log (log_q),
        .idx     (idx),
        .last    (idx_last)
    );

    colseq_window #(.COL_W(COL_W), .MAX_BL(MAX_BL)) u_win (
        .base       (base_q),
        .idx        (idx),
        .len_log    (log_q),
        .interleave (inter_q),
        .col        (win_col)
    );

    // Output decode from the state register
    always_comb begin
        beat_valid = 1'b0;
        beat_col   = '0;
        beat_last  = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_BURST: begin
                beat_valid = 1'b1;
                beat_col   = win_col;
                beat_last  = idx_last;
            end
            default:  ;
        endcase
    end
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
    parameter int COL_W  = 9,
    parameter int MAX_BL = 8,
    localparam int IDX_W = $clog2(MAX_BL)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             stop,
    input logic             beat_valid,
    input logic [COL_W-1:0] beat_col,
    input logic             beat_last
);
    assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (beat_valid && beat_col == $past(start_col)));

    assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !start) |=>
            (!beat_valid || $past(start) ||
             beat_col[COL_W-1:IDX_W] == $past(beat_col[COL_W-1:IDX_W])));

    assert_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_last && !start) |=> !beat_valid);

    assert_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> !beat_valid);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid |-> (beat_col == '0 && !beat_last));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W), .MAX_BL(MAX_BL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_col  (start_col),
    .stop       (stop),
    .beat_valid (beat_valid),
    .beat_col   (beat_col),
    .beat_last  (beat_last)
);

// File: tb/tb_burst_col_seq.sv
`timescale 1ns/1ps
module tb_burst_col_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [8:0] start_col = '0;
    logic [1:0] len_sel = 2'b01;
    logic       interleave = 1'b0;
    logic       stop = 1'b0;
    logic       beat_valid;
    logic [8:0] beat_col;
    logic       beat_last;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_col_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
        .len_sel(len_sel), .interleave(interleave), .stop(stop),
        .beat_valid(beat_valid), .beat_col(beat_col), .beat_last(beat_last)
    );

    function automatic int bl_of(input logic [1:0] code);
        return (code == 2'b00) ? 2 : (1 << code);
    endfunction

    function automatic logic [8:0] exp_col(input logic [8:0] c, input logic [1:0] code,
                                           input logic inter, input int i);
        logic [8:0] mask, low;
        mask = 9'(bl_of(code) - 1);
        low  = inter ? (c ^ 9'(i)) : (c + 9'(i));
        return (c & ~mask) | (low & mask);
    endfunction

    task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // start a burst at a negedge; returns on the negedge showing beat 0
    task automatic launch(input logic [8:0] c, input logic [1:0] code, input logic inter);
        start_col = c; len_sel = code; interleave = inter; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // check all beats from beat 0 (already visible); scrambles settings (R10)
    task automatic walk(input string req, input logic [8:0] c, input logic [1:0] code,
                        input logic inter);
        int bl = bl_of(code);
        for (int i = 0; i < bl; i++) begin
            if (i == 0) begin
                start_col = 9'($urandom); len_sel = 2'($urandom); interleave = 1'($urandom);
            end
            check(req, {beat_valid, beat_last, beat_col},
                  {1'b1, (i == bl - 1), exp_col(c, code, inter, i)});
            @(negedge clk);
        end
        check("R7 drain", {beat_valid, beat_last, beat_col}, 11'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    initial begin
        void'($urandom(32'd20240));
        repeat (3) @(negedge clk);
        check("R1 in reset", {beat_valid, beat_last, beat_col}, 11'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 after reset", {beat_valid, beat_last, beat_col}, 11'd0);

        // directed orderings from the requirements
        launch(9'h1A2, 2'b10, 1'b0); walk("R3 seq BL4 start2", 9'h1A2, 2'b10, 1'b0);
        launch(9'h0F5, 2'b11, 1'b0); walk("R3 seq BL8 start5", 9'h0F5, 2'b11, 1'b0);
        launch(9'h0F5, 2'b11, 1'b1); walk("R4 xor BL8 start5", 9'h0F5, 2'b11, 1'b1);
        launch(9'h131, 2'b10, 1'b1); walk("R4 xor BL4 start1", 9'h131, 2'b10, 1'b1);
        launch(9'h1FF, 2'b01, 1'b0); walk("R6 BL2", 9'h1FF, 2'b01, 1'b0);
        launch(9'h0C3, 2'b00, 1'b1); walk("R6 code0 as BL2", 9'h0C3, 2'b00, 1'b1);
        launch(9'h1FF, 2'b11, 1'b0); walk("R5 upper bits BL8", 9'h1FF, 2'b11, 1'b0);

        // R8: restart on the cycle right after a start
        launch(9'h010, 2'b11, 1'b0);
        check("R2 beat0", {beat_valid, beat_col}, {1'b1, 9'h010});
        launch(9'h0AB, 2'b10, 1'b1);
        walk("R8 back-to-back restart", 9'h0AB, 2'b10, 1'b1);

        // R8: restart mid-burst
        launch(9'h020, 2'b11, 1'b0);
        @(negedge clk); @(negedge clk);
        launch(9'h147, 2'b11, 1'b0);
        walk("R8 mid-burst restart", 9'h147, 2'b11, 1'b0);

        // R9: stop ends burst
        launch(9'h033, 2'b11, 1'b1);
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        check("R9 stop", {beat_valid, beat_last, beat_col}, 11'd0);
        @(negedge clk);
        check("R9 stays idle", {beat_valid, beat_last, beat_col}, 11'd0);

        // R9: start with stop wins
        launch(9'h044, 2'b10, 1'b0);
        stop = 1'b1;
        launch(9'h0E6, 2'b10, 1'b0);
        stop = 1'b0;
        walk("R9 start beats stop", 9'h0E6, 2'b10, 1'b0);

        // random bursts (R10 scramble inside walk)
        for (int n = 0; n < 60; n++) begin
            logic [8:0] c  = 9'($urandom);
            logic [1:0] cd = 2'($urandom);
            logic       it = 1'($urandom);
            launch(c, cd, it);
            walk("R10 random burst", c, cd, it);
            repeat ($urandom % 3) @(negedge clk);
        end

        done = 1'b1;
        finish_up();
    end
endmodule